// File: doc/BRIEF.md
# Transparent Receive Descriptor Controller

This block sits behind a serial receiver front end in transparent mode. It takes one received byte per cycle into a small queue, then moves the bytes into the current receive buffer through a byte write port, with one write per cycle while the memory side is ready. Each buffer is described by a descriptor. A descriptor holds a 16-bit status word and a byte count. The host arms a descriptor by setting its Empty flag. It reads the status word and the byte count back through a read port.

A buffer is closed when one of four things happens: it fills, an error is seen, a close command arrives, or an enter-hunt command arrives. On close the block clears the Empty flag, records the error flags and the byte count, and pulses a receive interrupt if the descriptor asks for one. It then steps to the next descriptor in the ring. Errors and the hunt command put the receiver in hunt mode. In hunt mode, bytes are thrown away until a sync pulse arrives and the current descriptor is armed.

There are two error cases. Queue overrun replaces the newest queued byte. Carrier loss outranks every other error and ends the message at once.

Top module: `rx_bd_ctrl`

## Requirements
- R1: After reset the block is hunting (`hunting`=1) on descriptor 0. `rx_irq` and `buf_we` are low, and every status word and byte count reads 0.
- R2: While hunting, incoming bytes, `cmd_close` and `cmd_hunt` have no effect. The block leaves hunt only on a cycle where `sync`=1 and the current descriptor's Empty flag (status bit 15) is 1.
- R3: With `wide_mode`=0, a queued byte is written as soon as one byte is queued. With `wide_mode`=1, writes start only once 4 bytes are queued and then go on until the queue is empty. A write happens only in a cycle where `buf_ready`=1, and byte offsets count up from 0 within each buffer.
- R4: `cmd_close` while receiving drains the queue, then closes the buffer. Reception then goes on in the next descriptor if its Empty flag is 1; otherwise the block hunts.
- R5: `cmd_hunt` while receiving drains the queue, closes the buffer without setting any error flag, and enters hunt mode.
- R6: Writing byte number BUF_LEN of a buffer closes it in that same cycle, with a byte count of BUF_LEN. Reception continues in the next descriptor without hunting when that descriptor is armed.
- R7: When a byte arrives while the queue holds DEPTH bytes and no write happens that cycle, the new byte replaces the newest queued byte. The buffer is then drained and closed with OV (status bit 1) set, and the block hunts.
- R8: `carrier`=0 while receiving drops that cycle's byte, drains the queue, closes with CD (status bit 0) set, and hunts. Carrier loss outranks overrun, so OV stays 0 when both occur together.
- R9: When a full buffer and carrier loss happen in the same cycle, the closed descriptor carries the CD flag and the block hunts.
- R10: On close, `rx_irq` is high for exactly one cycle, in the cycle after the close, if the descriptor's interrupt-enable bit (status bit 12) is 1. Otherwise it stays low.
- R11: After a close, the next descriptor index is 0 if the closed descriptor's wrap bit (status bit 13) is 1, or if it was the last descriptor. Otherwise the index is the closed index plus 1.
- R12: A close clears bit 15, writes bits 1 and 0 from the close cause, and leaves all other status bits as the host wrote them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_valid | input | 1 | A received byte is present this cycle |
| rx_data | input | 8 | Received byte |
| carrier | input | 1 | Carrier present; low while receiving is an error |
| sync | input | 1 | Leave hunt mode (start of message) |
| wide_mode | input | 1 | 0: write per byte, 1: write once 4 bytes are queued |
| cmd_hunt | input | 1 | Close the buffer and enter hunt mode |
| cmd_close | input | 1 | Close the buffer and move to the next one |
| host_we | input | 1 | Host writes a status word (count cleared) |
| host_idx | input | IW | Descriptor written by the host |
| host_wdata | input | 16 | Status word from the host |
| rd_idx | input | IW | Descriptor to read back |
| rd_status | output | 16 | Status word of `rd_idx` |
| rd_len | output | 16 | Byte count of `rd_idx` |
| buf_ready | input | 1 | Buffer memory accepts a write this cycle |
| buf_we | output | 1 | Buffer byte write |
| buf_desc | output | IW | Descriptor whose buffer is written |
| buf_off | output | 16 | Byte offset in the buffer |
| buf_data | output | 8 | Byte written |
| rx_irq | output | 1 | Receive interrupt pulse |
| hunting | output | 1 | Receiver is in hunt mode |
| cur_idx | output | IW | Current descriptor index |

## Verification
The bench targets these corner cases:

- **Overrun with the write port stalled.** A design that drops the new byte instead of replacing the newest entry would store the wrong fourth byte.
- **Carrier lost while the queue is full and a byte arrives.** A design with the wrong priority would set OV beside CD.
- **Buffer fills in the same cycle carrier drops.** A wrong design would either lose the CD flag or keep receiving instead of hunting.
- **Wide-mode threshold.** A design that writes before four bytes are queued would show writes early.
- **Sync while the current descriptor is still owned by the host.** A design that leaves hunt anyway would write into a descriptor the host has not given back.

// File: rtl/rx_bd_ctrl.sv
module rx_bd_ctrl #(
  parameter int NDESC   = 4,
  parameter int BUF_LEN = 8,
  parameter int DEPTH   = 4,
  localparam int IW = $clog2(NDESC),
  localparam int PW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_valid,
  input  logic [7:0]    rx_data,
  input  logic          carrier,
  input  logic          sync,
  input  logic          wide_mode,
  input  logic          cmd_hunt,
  input  logic          cmd_close,
  input  logic          host_we,
  input  logic [IW-1:0] host_idx,
  input  logic [15:0]   host_wdata,
  input  logic [IW-1:0] rd_idx,
  output logic [15:0]   rd_status,
  output logic [15:0]   rd_len,
  input  logic          buf_ready,
  output logic          buf_we,
  output logic [IW-1:0] buf_desc,
  output logic [15:0]   buf_off,
  output logic [7:0]    buf_data,
  output logic          rx_irq,
  output logic          hunting,
  output logic [IW-1:0] cur_idx
);
  localparam int E_B = 15, W_B = 13, I_B = 12;
  localparam logic [CW-1:0] WIDE_N = CW'(4);
  localparam logic [CW-1:0] FULL_N = CW'(DEPTH);

  typedef enum logic [1:0] {S_HUNT, S_RECV, S_FLUSH} st_t;
  st_t st;

  logic [7:0]    q [DEPTH];
  logic [PW-1:0] rp, wp;
  logic [CW-1:0] cnt;
  logic          burst;
  logic [15:0]   stat [NDESC];
  logic [15:0]   blen [NDESC];
  logic [15:0]   wr_cnt;
  logic [IW-1:0] idx;
  logic          c_ov, c_cd, c_hunt, irq_q;

  function automatic logic [PW-1:0] inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  wire recv  = (st == S_RECV);
  wire flush = (st == S_FLUSH);
  wire thr   = wide_mode ? (cnt >= WIDE_N) : (cnt != '0);
  wire pop   = (cnt != '0) && buf_ready && ((recv && (burst || thr)) || flush);

  wire err_cd = recv && !carrier;
  wire err_ov = recv && carrier && rx_valid && (cnt == FULL_N) && !pop;

  wire full_close = pop && (wr_cnt == 16'(BUF_LEN - 1));
  wire flush_done = flush && (cnt == '0);
  wire close      = full_close || flush_done;
  wire go_flush   = recv && !full_close && (err_cd || err_ov || cmd_hunt || cmd_close);

  wire f_cd = c_cd | err_cd;
  wire f_ov = c_ov | err_ov;

  wire [IW-1:0] nxt = (stat[idx][W_B] || idx == IW'(NDESC - 1)) ? '0 : idx + 1'b1;
  wire next_armed   = (nxt != idx) && stat[nxt][E_B];
  wire to_hunt      = f_cd | f_ov | c_hunt | (recv & cmd_hunt) | !next_armed;
  wire clear        = close && to_hunt;

  wire push_ok   = recv && rx_valid && carrier && !clear;
  wire push_norm = push_ok && ((cnt != FULL_N) || pop);

  wire [PW-1:0] wp_last = (wp == '0) ? PW'(DEPTH - 1) : wp - 1'b1;

  assign buf_we    = pop;
  assign buf_desc  = idx;
  assign buf_off   = wr_cnt;
  assign buf_data  = q[rp];
  assign rx_irq    = irq_q;
  assign hunting   = (st == S_HUNT);
  assign cur_idx   = idx;
  assign rd_status = stat[rd_idx];
  assign rd_len    = blen[rd_idx];

  always_ff @(posedge clk) begin
    if (push_norm) q[wp] <= rx_data;
    else if (err_ov) q[wp_last] <= rx_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rp <= '0; wp <= '0; cnt <= '0; burst <= 1'b0;
    end else if (clear) begin
      rp <= '0; wp <= '0; cnt <= '0; burst <= 1'b0;
    end else begin
      if (pop) rp <= inc(rp);
      if (push_norm) wp <= inc(wp);
      cnt <= cnt + CW'(push_norm) - CW'(pop);
      if (!recv) burst <= 1'b0;
      else if (pop && cnt == CW'(1) && !push_norm) burst <= 1'b0;
      else if (thr) burst <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NDESC; i++) begin
        stat[i] <= '0;
        blen[i] <= '0;
      end
    end else begin
      if (host_we) begin
        stat[host_idx] <= host_wdata;
        blen[host_idx] <= '0;
      end
      if (close) begin
        stat[idx] <= {1'b0, stat[idx][14:2], f_ov, f_cd};
        blen[idx] <= wr_cnt + 16'(pop);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_HUNT; idx <= '0; wr_cnt <= '0;
      c_ov <= 1'b0; c_cd <= 1'b0; c_hunt <= 1'b0; irq_q <= 1'b0;
    end else begin
      irq_q <= close && stat[idx][I_B];
      if (close) begin
        idx    <= nxt;
        wr_cnt <= '0;
        c_ov <= 1'b0; c_cd <= 1'b0; c_hunt <= 1'b0;
        st     <= to_hunt ? S_HUNT : S_RECV;
      end else begin
        case (st)
          S_HUNT: if (sync && stat[idx][E_B]) begin
            st <= S_RECV;
            wr_cnt <= '0;
          end
          S_RECV: begin
            wr_cnt <= wr_cnt + 16'(pop);
            if (go_flush) begin
              st     <= S_FLUSH;
              c_cd   <= err_cd;
              c_ov   <= err_ov;
              c_hunt <= cmd_hunt;
            end
          end
          S_FLUSH: wr_cnt <= wr_cnt + 16'(pop);
          default: st <= S_HUNT;
        endcase
      end
    end
  end
endmodule

// File: rtl/rx_bd_ctrl_chk.sv
module rx_bd_ctrl_chk #(
  parameter int BUF_LEN = 8
) (
  input logic        clk,
  input logic        rst_n,
  input logic        rx_irq,
  input logic        hunting,
  input logic        sync,
  input logic        buf_we,
  input logic        buf_ready,
  input logic [15:0] buf_off
);
  a_r10_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |=> !rx_irq);

  a_r2_hunt_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    hunting |-> !buf_we);

  a_r2_sync_to_leave: assert property (@(posedge clk) disable iff (!rst_n)
    (hunting && !sync) |=> hunting);

  a_r3_write_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
    buf_we |-> buf_ready);

  a_r6_offset_bound: assert property (@(posedge clk) disable iff (!rst_n)
    buf_we |-> (buf_off < 16'(BUF_LEN)));
endmodule

bind rx_bd_ctrl rx_bd_ctrl_chk #(.BUF_LEN(BUF_LEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_irq(rx_irq), .hunting(hunting), .sync(sync),
  .buf_we(buf_we), .buf_ready(buf_ready), .buf_off(buf_off)
);

// File: tb/rx_bd_ctrl_bench.sv
module rx_bd_ctrl_bench;
  localparam int CLK_NS  = 10;
  localparam int NDESC   = 4;
  localparam int BUF_LEN = 8;
  localparam int IW      = 2;

  logic clk = 0, rst_n = 0;
  logic rx_valid = 0, carrier = 1, sync = 0, wide_mode = 0;
  logic cmd_hunt = 0, cmd_close = 0, host_we = 0, buf_ready = 1;
  logic [7:0] rx_data = 0;
  logic [IW-1:0] host_idx = 0, rd_idx = 0;
  logic [15:0] host_wdata = 0;
  logic [15:0] rd_status, rd_len, buf_off;
  logic buf_we, rx_irq, hunting;
  logic [IW-1:0] buf_desc, cur_idx;
  logic [7:0] buf_data;

  int errors = 0, checks = 0, wcount = 0, irqs = 0;
  bit done = 0;
  logic [7:0] mem [NDESC*BUF_LEN];

  rx_bd_ctrl #(.NDESC(NDESC), .BUF_LEN(BUF_LEN), .DEPTH(4)) u_rx_bd_ctrl (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .carrier(carrier), .sync(sync), .wide_mode(wide_mode),
    .cmd_hunt(cmd_hunt), .cmd_close(cmd_close), .host_we(host_we),
    .host_idx(host_idx), .host_wdata(host_wdata), .rd_idx(rd_idx),
    .rd_status(rd_status), .rd_len(rd_len), .buf_ready(buf_ready),
    .buf_we(buf_we), .buf_desc(buf_desc), .buf_off(buf_off), .buf_data(buf_data),
    .rx_irq(rx_irq), .hunting(hunting), .cur_idx(cur_idx));

  always #(CLK_NS/2) clk = ~clk;

  always @(negedge clk) begin
    if (buf_we) begin
      mem[int'(buf_desc)*BUF_LEN + int'(buf_off)] <= buf_data;
      wcount++;
    end
    if (rx_irq) irqs++;
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic step(int n = 1);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic send(logic [7:0] b);
    rx_valid = 1; rx_data = b; step(); rx_valid = 0;
  endtask

  task automatic host_set(int i, logic [15:0] w);
    host_we = 1; host_idx = IW'(i); host_wdata = w; step(); host_we = 0;
  endtask

  task automatic pulse_sync();
    sync = 1; step(); sync = 0;
  endtask

  task automatic check_desc(string req, int i, int st, int ln);
    rd_idx = IW'(i); #1;
    chk({req, " status"}, int'(rd_status), st);
    chk({req, " length"}, int'(rd_len), ln);
  endtask

  task automatic t_reset();
    chk("R1 hunting", int'(hunting), 1);
    chk("R1 index", int'(cur_idx), 0);
    chk("R1 irq", int'(rx_irq), 0);
    chk("R1 write", int'(buf_we), 0);
    for (int i = 0; i < NDESC; i++) check_desc("R1", i, 0, 0);
  endtask

  task automatic t_close_cmd();
    int w0 = wcount, q0 = irqs;
    host_set(0, 16'h9000); host_set(1, 16'h9000);
    host_set(2, 16'h8000); host_set(3, 16'hB000);
    pulse_sync();
    send(8'h11); send(8'h12); send(8'h13); step(2);
    chk("R3 narrow writes", wcount - w0, 3);
    chk("R3 offset order", int'(mem[2]), 8'h13);
    cmd_close = 1; step(); cmd_close = 0; step(3);
    check_desc("R4", 0, 16'h1000, 3);
    chk("R10 irq on close", irqs - q0, 1);
    chk("R4 stays receiving", int'(hunting), 0);
    chk("R11 next index", int'(cur_idx), 1);
  endtask

  task automatic t_wide_hunt();
    int w0 = wcount, q0 = irqs;
    wide_mode = 1;
    send(8'h21); send(8'h22); send(8'h23); step(2);
    chk("R3 wide holds below 4", wcount - w0, 0);
    send(8'h24); step(6);
    chk("R3 wide drains 4", wcount - w0, 4);
    chk("R3 wide data", int'(mem[BUF_LEN + 3]), 8'h24);
    cmd_hunt = 1; step(); cmd_hunt = 0; step(3);
    wide_mode = 0;
    check_desc("R5", 1, 16'h1000, 4);
    chk("R5 hunting", int'(hunting), 1);
    chk("R10 irq hunt close", irqs - q0, 1);
    chk("R11 index", int'(cur_idx), 2);
  endtask

  task automatic t_full();
    int q0 = irqs;
    pulse_sync();
    for (int k = 0; k < BUF_LEN; k++) send(8'h31 + 8'(k));
    step(3);
    check_desc("R6", 2, 16'h0000, BUF_LEN);
    chk("R10 no irq when disabled", irqs - q0, 0);
    chk("R6 no hunt", int'(hunting), 0);
    chk("R6 last byte", int'(mem[2*BUF_LEN + BUF_LEN - 1]), 8'h31 + BUF_LEN - 1);
    chk("R11 index", int'(cur_idx), 3);
  endtask

  task automatic t_overrun();
    int w0 = wcount, q0 = irqs;
    buf_ready = 0;
    for (int k = 0; k < 5; k++) send(8'h51 + 8'(k));
    chk("R7 no write while stalled", wcount - w0, 0);
    buf_ready = 1; step(8);
    check_desc("R7 R12", 3, 16'h3002, 4);
    chk("R7 replaced byte", int'(mem[3*BUF_LEN + 3]), 8'h55);
    chk("R7 earlier byte kept", int'(mem[3*BUF_LEN + 2]), 8'h53);
    chk("R7 hunting", int'(hunting), 1);
    chk("R11 wrap", int'(cur_idx), 0);
    chk("R10 irq", irqs - q0, 1);
  endtask

  task automatic t_carrier();
    host_set(0, 16'h9000);
    pulse_sync();
    send(8'h61); send(8'h62); step(2);
    buf_ready = 0;
    for (int k = 0; k < 4; k++) send(8'h63 + 8'(k));
    carrier = 0; rx_valid = 1; rx_data = 8'h67; step();
    rx_valid = 0; carrier = 1;
    buf_ready = 1; step(8);
    check_desc("R8", 0, 16'h1001, 6);
    chk("R8 queued byte kept", int'(mem[5]), 8'h66);
    chk("R8 hunting", int'(hunting), 1);
    chk("R11 index", int'(cur_idx), 1);
  endtask

  task automatic t_hunt_wait();
    int w0 = wcount, q0 = irqs;
    pulse_sync();
    send(8'h71); send(8'h72);
    cmd_close = 1; step(); cmd_close = 0;
    cmd_hunt = 1; step(); cmd_hunt = 0; step(2);
    chk("R2 stays hunting", int'(hunting), 1);
    chk("R2 no writes", wcount - w0, 0);
    chk("R2 no irq", irqs - q0, 0);
    check_desc("R2", 1, 16'h1000, 4);
    host_set(1, 16'h9000);
    send(8'h73); send(8'h74); step(2);
    chk("R2 bytes before sync dropped", wcount - w0, 0);
    chk("R2 still hunting", int'(hunting), 1);
  endtask

  task automatic t_full_and_cd();
    int q0 = irqs;
    pulse_sync();
    for (int k = 0; k < BUF_LEN; k++) send(8'h81 + 8'(k));
    carrier = 0; step(); carrier = 1; step(3);
    check_desc("R9", 1, 16'h1001, BUF_LEN);
    chk("R9 hunting", int'(hunting), 1);
    chk("R9 last byte", int'(mem[BUF_LEN + BUF_LEN - 1]), 8'h81 + BUF_LEN - 1);
    chk("R9 irq", irqs - q0, 1);
    chk("R11 index", int'(cur_idx), 2);
  endtask

  initial begin
    step(3);
    rst_n = 1;
    step();
    t_reset();
    t_close_cmd();
    t_wide_hunt();
    t_full();
    t_overrun();
    t_carrier();
    t_hunt_wait();
    t_full_and_cd();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule